// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block lets an external controller read and write a small bank of device configuration registers over a 4-wire serial link. The link has a clock, an active-low select, a data input and a data output. Every access is one fixed frame of sixteen serial clocks. The first eight bits carry a command: a direction flag and a four-bit register address. The last eight bits carry data. The block runs on the device's own clock. It synchronises the serial pins into that clock and finds the serial clock edges and the select edges in that domain.

A write finishes in one frame, and during that frame the controller sees the old contents of the register it names. A read takes two frames. The first frame names the address. The second frame shifts out the register that the first frame named, and at the same time loads its own address for the next read. A register or the address pointer changes only when the select rises after exactly sixteen clocks. Any other frame length is dropped without effect.

An enable input chooses the source of the device configuration. When it is high, the main configuration comes from a register and the power-down request is forced off. When it is low, the direct control pins drive the configuration and the serial port is shut off.

Top module: `spi_cfg_slave`

## Requirements
- R1: The pointer and the registers change only on a select rising edge that follows exactly 16 serial clock rising edges. A frame with fewer or more edges changes nothing.
- R2: The serial input is sampled on serial clock rising edges, most significant bit first. Word bit 15 is the direction (1 read, 0 write), bits 14:12 are zero, bits 11:8 are the address and bits 7:0 are the data.
- R3: The serial output changes only after serial clock falling edges. It is low during the command field. Data bit 7 appears after the 8th falling edge and data bit 0 after the 15th.
- R4: A write frame updates the addressed register at the select rising edge. Its data field returns that register's value from before the write.
- R5: A read frame returns the register named by the pointer, which is the address of the last completed frame, and then loads its own address into the pointer.
- R6: Write frames also load the pointer with their address.
- R7: Only addresses 0, 1, 2 and 5 are implemented. All other addresses read as zero and discard writes.
- R8: After reset the pointer is 0, the serial output is low, and each implemented register at address a holds {a, ~a} (0x0F, 0x1E, 0x2D, 0x5A).
- R9: While the enable is high, cfg_main equals register 0, pin_cfg has no effect, and cfg_pd stays low whatever pin_pd does.
- R10: While the enable is low, cfg_main follows pin_cfg and cfg_pd follows pin_pd. Serial frames change neither the registers nor the pointer.
- R11: Each select falling edge starts a new frame from bit zero, including after an aborted frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_en | input | 1 | 1 selects register control, 0 selects direct pins |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_sdi | input | 1 | Serial data into the block |
| spi_sdo | output | 1 | Serial data out of the block |
| pin_cfg | input | 8 | Direct configuration pins |
| pin_pd | input | 1 | Direct power-down pin |
| cfg_main | output | 8 | Main configuration to the device |
| cfg_pd | output | 1 | Power-down request to the device |

## Verification
The bench uses the default parameters: two synchroniser stages, the implemented-address mask 0x0027 and main register 0. With this mask the defaults of all four implemented registers and the gaps at addresses 3 and 4 can be observed, so zero reads and discarded writes are exercised next to live registers. The two-stage synchroniser allows a serial half period of eight device clocks. This keeps each output bit stable well before the next rising edge, and aborted frames of 10 and 17 clocks can sit directly next to full frames.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
    localparam int FRAME_BITS = 16;
    localparam int CMD_BITS   = 8;
    localparam int DATA_W     = FRAME_BITS - CMD_BITS;
    localparam int ADDR_W     = 4;
    localparam int NUM_REGS   = 1 << ADDR_W;
    localparam int RW_BIT     = FRAME_BITS - 1;
    localparam int ADDR_LSB   = DATA_W;
    localparam int CNT_MAX    = FRAME_BITS + 1;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // power-on value of an implemented register: address in the upper nibble, its inverse below
    function automatic data_t reg_default(addr_t a);
        return {a, ~a};
    endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic sdi_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_rise,
    output logic cs_fall,
    output logic cs_low,
    output logic sdi_s
);
    typedef struct packed {
        logic [STAGES:0]   sclk;
        logic [STAGES:0]   csn;
        logic [STAGES-1:0] sdi;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d      = q;
        d.sclk = (q.sclk << 1) | (STAGES+1)'(sclk_i);
        d.csn  = (q.csn  << 1) | (STAGES+1)'(cs_n_i);
        d.sdi  = (q.sdi  << 1) | STAGES'(sdi_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sclk <= '0;
            q.csn  <= '1;
            q.sdi  <= '0;
        end else begin
            q <= d;
        end
    end

    // sdi is taken from the same depth as the newest sclk stage so data lines up with its edge
    assign sclk_rise =  q.sclk[STAGES-1] & ~q.sclk[STAGES];
    assign sclk_fall = ~q.sclk[STAGES-1] &  q.sclk[STAGES];
    assign cs_rise   =  q.csn[STAGES-1]  & ~q.csn[STAGES];
    assign cs_fall   = ~q.csn[STAGES-1]  &  q.csn[STAGES];
    assign cs_low    = ~q.csn[STAGES-1];
    assign sdi_s     =  q.sdi[STAGES-1];
endmodule

// File: rtl/spi_shift_frame.sv
module spi_shift_frame
    import spi_cfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  sclk_rise,
    input  logic  sclk_fall,
    input  logic  cs_rise,
    input  logic  cs_fall,
    input  logic  cs_low,
    input  logic  sdi_s,
    input  data_t rd_data,
    output addr_t rd_addr,
    output logic  wr_en,
    output addr_t wr_addr,
    output data_t wr_data,
    output addr_t ptr,
    output logic  sdo
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(CMD_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CNT_MAX);

    typedef struct packed {
        logic [FRAME_BITS-1:0] shreg;
        logic [CNT_W-1:0]      cnt;
        data_t                 out_sr;
        logic                  sdo;
        addr_t                 ptr;
    } frame_t;

    frame_t d, q;

    // once the command byte is complete: read uses the pointer, write uses its own address
    assign rd_addr = q.shreg[CMD_BITS-1] ? q.ptr : q.shreg[ADDR_W-1:0];
    assign wr_addr = q.shreg[ADDR_LSB +: ADDR_W];
    assign wr_data = q.shreg[DATA_W-1:0];

    always_comb begin
        d     = q;
        wr_en = 1'b0;
        if (!en) begin
            d.cnt = '0;
        end else begin
            if (cs_fall) begin
                d.cnt    = '0;
                d.sdo    = 1'b0;
                d.out_sr = '0;
            end else if (cs_low) begin
                if (sclk_rise) begin
                    d.shreg = {q.shreg[FRAME_BITS-2:0], sdi_s};
                    if (q.cnt != CNT_SAT)
                        d.cnt = q.cnt + 1'b1;
                end
                if (sclk_fall) begin
                    if (q.cnt == CNT_CMD) begin
                        d.sdo    = rd_data[DATA_W-1];
                        d.out_sr = {rd_data[DATA_W-2:0], 1'b0};
                    end else if (q.cnt > CNT_CMD && q.cnt < CNT_FULL) begin
                        d.sdo    = q.out_sr[DATA_W-1];
                        d.out_sr = {q.out_sr[DATA_W-2:0], 1'b0};
                    end else begin
                        d.sdo    = 1'b0;
                    end
                end
            end
            if (cs_rise && q.cnt == CNT_FULL) begin
                d.ptr = q.shreg[ADDR_LSB +: ADDR_W];
                wr_en = ~q.shreg[RW_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ptr = q.ptr;
    assign sdo = q.sdo;
endmodule

// File: rtl/spi_cfg_regfile.sv
module spi_cfg_regfile
    import spi_cfg_pkg::*;
#(
    parameter logic [NUM_REGS-1:0] IMPL_MASK = 16'h0027,
    parameter int                  MAIN_ADDR = 0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  addr_t wr_addr,
    input  data_t wr_data,
    input  addr_t rd_addr,
    output data_t rd_data,
    output data_t main_val
);
    data_t regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (IMPL_MASK[g]) begin : g_impl
            data_t r_d, r_q;
            always_comb begin
                r_d = r_q;
                if (wr_en && wr_addr == ADDR_W'(g))
                    r_d = wr_data;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r_q <= reg_default(ADDR_W'(g));
                else        r_q <= r_d;
            end
            assign regs[g] = r_q;
        end else begin : g_hole
            assign regs[g] = '0;
        end
    end

    assign rd_data  = regs[rd_addr];
    assign main_val = regs[MAIN_ADDR];
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
    import spi_cfg_pkg::*;
#(
    parameter int                  SYNC_STAGES = 2,
    parameter logic [NUM_REGS-1:0] IMPL_MASK   = 16'h0027,
    parameter int                  MAIN_ADDR   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_en,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_sdi,
    output logic              spi_sdo,
    input  logic [DATA_W-1:0] pin_cfg,
    input  logic              pin_pd,
    output logic [DATA_W-1:0] cfg_main,
    output logic              cfg_pd
);
    logic  sclk_rise, sclk_fall, cs_rise, cs_fall, cs_low, sdi_s;
    logic  wr_en;
    addr_t rd_addr, wr_addr, ptr_q;
    data_t rd_data, wr_data, main_val;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (spi_sclk),
        .cs_n_i    (spi_cs_n),
        .sdi_i     (spi_sdi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_rise   (cs_rise),
        .cs_fall   (cs_fall),
        .cs_low    (cs_low),
        .sdi_s     (sdi_s)
    );

    spi_shift_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (spi_en),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_rise   (cs_rise),
        .cs_fall   (cs_fall),
        .cs_low    (cs_low),
        .sdi_s     (sdi_s),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ptr       (ptr_q),
        .sdo       (spi_sdo)
    );

    spi_cfg_regfile #(.IMPL_MASK(IMPL_MASK), .MAIN_ADDR(MAIN_ADDR)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .main_val (main_val)
    );

    // source select: registers when the serial port owns the configuration, pins otherwise
    always_comb begin
        if (spi_en) begin
            cfg_main = main_val;
            cfg_pd   = 1'b0;
        end else begin
            cfg_main = pin_cfg;
            cfg_pd   = pin_pd;
        end
    end
endmodule

// File: rtl/spi_cfg_slave_chk.sv
module spi_cfg_slave_chk
    import spi_cfg_pkg::*;
#(
    parameter logic [NUM_REGS-1:0] IMPL_MASK = 16'h0027
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_en,
    input logic              spi_sdo,
    input logic [DATA_W-1:0] cfg_main,
    input logic              cfg_pd,
    input logic              sclk_fall,
    input logic              cs_fall,
    input logic              cs_rise,
    input logic              wr_en,
    input logic [ADDR_W-1:0] ptr_q,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data
);
    a_r3_sdo_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_fall && !cs_fall) |=> $stable(spi_sdo));

    a_r1_ptr_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |=> $stable(ptr_q));

    a_r10_no_write_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_en |-> !wr_en);

    a_r7_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !IMPL_MASK[rd_addr] |-> rd_data == '0);

    a_r9_pins_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && !wr_en) |=> (!spi_en || $stable(cfg_main)));

    a_r9_pd_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        spi_en |-> !cfg_pd);
endmodule

bind spi_cfg_slave spi_cfg_slave_chk #(.IMPL_MASK(IMPL_MASK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_en    (spi_en),
    .spi_sdo   (spi_sdo),
    .cfg_main  (cfg_main),
    .cfg_pd    (cfg_pd),
    .sclk_fall (sclk_fall),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .wr_en     (wr_en),
    .ptr_q     (ptr_q),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
);

// File: tb/spi_cfg_slave_tb.sv
`timescale 1ns/1ps
module spi_cfg_slave_tb;
    localparam int          HALF = 8;
    localparam logic [15:0] IMPL = 16'h0027;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_en = 1'b1;
    logic       spi_sclk = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_sdi = 1'b0;
    logic       spi_sdo;
    logic [7:0] pin_cfg = 8'h00;
    logic       pin_pd = 1'b1;
    logic [7:0] cfg_main;
    logic       cfg_pd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] mdl [16];
    logic [3:0] mptr;

    always #2 clk = ~clk;

    spi_cfg_slave u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_en   (spi_en),
        .spi_sclk (spi_sclk),
        .spi_cs_n (spi_cs_n),
        .spi_sdi  (spi_sdi),
        .spi_sdo  (spi_sdo),
        .pin_cfg  (pin_cfg),
        .pin_pd   (pin_pd),
        .cfg_main (cfg_main),
        .cfg_pd   (cfg_pd)
    );

    function automatic logic [15:0] wr_w(input logic [3:0] a, input logic [7:0] v);
        return {1'b0, 3'b000, a, v};
    endfunction

    function automatic logic [15:0] rd_w(input logic [3:0] a);
        return {1'b1, 3'b000, a, 8'h00};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // one frame of nclk serial clocks; the data field is checked against the model when the frame completes
    task automatic run_frame(input logic [15:0] word, input int nclk, input string req);
        logic [7:0] got;
        logic [7:0] exp_d;
        logic       cmd_hi;
        logic [3:0] a;
        a      = word[11:8];
        exp_d  = word[15] ? mdl[mptr] : mdl[a];
        got    = 8'h00;
        cmd_hi = 1'b0;
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nclk; i++) begin
            spi_sdi = (i < 16) ? word[15-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (i >= 8 && i <= 15) got[15-i] = spi_sdo;
            else if (i < 8 && spi_sdo) cmd_hi = 1'b1;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (2*HALF) @(negedge clk);
        if (nclk == 16 && spi_en) begin
            chk(req, got, exp_d);
            chk("R3 command field low", {7'd0, cmd_hi}, 8'h00);
            mptr = a;
            if (!word[15] && IMPL[a]) mdl[a] = word[7:0];
        end
    endtask

    task automatic t_reset();
        chk("R8 sdo after reset", {7'd0, spi_sdo}, 8'h00);
        chk("R9 cfg_main is reg0 default", cfg_main, 8'h0F);
        chk("R9 cfg_pd low with pin_pd high", {7'd0, cfg_pd}, 8'h00);
        run_frame(rd_w(4'd1), 16, "R8 pointer zero reads reg0");
    endtask

    task automatic t_defaults();
        run_frame(rd_w(4'd2), 16, "R5 R8 read addr1 default");
        run_frame(rd_w(4'd5), 16, "R5 R8 read addr2 default");
        run_frame(rd_w(4'd3), 16, "R5 R8 read addr5 default");
        run_frame(rd_w(4'd0), 16, "R7 R5 read hole addr3");
        chk("R8 default 0x5A model", mdl[5], 8'h5A);
    endtask

    task automatic t_write();
        run_frame(wr_w(4'd1, 8'hC3), 16, "R4 R2 write returns old value");
        run_frame(rd_w(4'd2), 16, "R6 pointer loaded by write");
        chk("R4 model updated", mdl[1], 8'hC3);
        run_frame(wr_w(4'd1, 8'h3A), 16, "R4 second write returns C3");
        run_frame(rd_w(4'd1), 16, "R6 R5 read after write");
    endtask

    task automatic t_hole();
        run_frame(wr_w(4'd4, 8'h77), 16, "R7 write to hole returns zero");
        run_frame(rd_w(4'd0), 16, "R7 hole discards write");
    endtask

    task automatic t_abort();
        run_frame(wr_w(4'd2, 8'h99), 10, "R1 short");
        run_frame(rd_w(4'd2), 16, "R1 R11 short frame left pointer");
        run_frame(wr_w(4'd2, 8'h44), 17, "R1 long");
        run_frame(rd_w(4'd5), 16, "R1 long frame left register 2");
        chk("R1 model reg2 unchanged", mdl[2], 8'h2D);
    endtask

    task automatic t_direct();
        spi_en  = 1'b0;
        pin_cfg = 8'h5C;
        pin_pd  = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 cfg_main from pins", cfg_main, 8'h5C);
        chk("R10 cfg_pd from pin", {7'd0, cfg_pd}, 8'h01);
        run_frame(wr_w(4'd0, 8'hAA), 16, "R10 ignored frame");
        pin_cfg = 8'hA3;
        pin_pd  = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 cfg_main tracks pins", cfg_main, 8'hA3);
        chk("R10 cfg_pd tracks pin", {7'd0, cfg_pd}, 8'h00);
        spi_en = 1'b1;
        pin_pd = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 R10 reg0 untouched by disabled frame", cfg_main, 8'h0F);
        chk("R9 pd blocked", {7'd0, cfg_pd}, 8'h00);
        pin_cfg = 8'h11;
        repeat (4) @(negedge clk);
        chk("R9 pins ignored", cfg_main, 8'h0F);
        run_frame(rd_w(4'd1), 16, "R10 pointer untouched by disabled frame");
        run_frame(wr_w(4'd0, 8'h3C), 16, "R4 write reg0");
        repeat (2) @(negedge clk);
        chk("R9 cfg_main follows reg0", cfg_main, 8'h3C);
    endtask

    initial begin
        for (int i = 0; i < 16; i++)
            mdl[i] = IMPL[i] ? {4'(i), ~4'(i)} : 8'h00;
        mptr = 4'd0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_defaults();
        t_write();
        t_hole();
        t_abort();
        t_direct();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule